// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block turns parallel sample words into a serial bit stream for a multichannel audio or telephony link. Words enter through a valid/ready port into a small internal queue. The serial side follows a bit clock and a frame sync that come in on pins and are sampled in the system clock domain. Each frame carries one or two phases. Each phase has its own element count and its own element width. Phase 2 either follows phase 1 directly or waits for a second frame sync. The delay from the sync to the first bit, the sync polarity, the clock edge that drives data and the bit order are all set by configuration pins. A configuration pin also picks what happens to a sync that arrives in the middle of a frame.

Back-pressure rules: a word is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only while the queue holds `QDEPTH` words. A source may hold `in_valid` high across cycles where `in_ready` is low, and the word is then taken later. The configuration pins must stay stable while `busy` is high.

Top module: `sfx_tx`

## Requirements
- R1: The element width code on `p1_wcode`/`p2_wcode` maps 0..7 to 8, 10, 12, 14, 16, 20, 24, 32 bits. An element sends only the low bits of its word, and word bits at or above the element width never appear on `sdata`.
- R2: The element count field `p1_cnt`/`p2_cnt` holds the number of elements minus one: 0 sends one element, 63 sends sixty-four. Elements of a phase follow each other with no gap.
- R3: With `p2_on` = 0 a frame is phase 1 only. With `p2_on` = 1 phase 2 follows, using its own width and count fields.
- R4: With `p2_resync` = 0, the first bit of phase 2 comes on the bit tick right after the last bit of phase 1. With `p2_resync` = 1, `sdata` is 0 until a new active sync edge, and phase 2 then starts after the programmed delay.
- R5: After an active sync edge seen on bit tick T, the first data bit appears on tick T + `lead_dly` (0..3), and `sdata` is 0 on the ticks before it.
- R6: `sync_low` = 0 makes a high `fsync` active. `sync_low` = 1 makes a low `fsync` active. A frame starts on a tick where the sync is active and was inactive on the previous tick.
- R7: `lsb_first` = 0 sends the most significant element bit first. `lsb_first` = 1 sends the least significant bit first.
- R8: An active sync edge during the delay or data part of a frame does one of two things. With `sync_keep` = 0 it drops the frame, pulses `sync_err` for one cycle, clears `busy` and forces `sdata` to 0. With `sync_keep` = 1 it is ignored, and the frame continues unchanged with no `sync_err`.
- R9: `rise_drive` = 1 makes rising `bclk` edges the bit ticks, and `rise_drive` = 0 makes falling edges the bit ticks. `sdata` changes only in the cycle after a bit tick.
- R10: If the queue is empty when an element starts, that element is sent as all zeros and `underrun` pulses for one cycle together with its first bit.
- R11: `busy` rises with the frame's starting sync edge and stays high through the last bit of the last enabled phase. It falls on the next tick, and `sdata` is 0 whenever `busy` is low.
- R12: Accepted words are sent in the order they were accepted, and `in_ready` is low only while the queue holds `QDEPTH` words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Queue can take a word |
| in_data | input | WORD_W | Word to send, low bits used |
| bclk | input | 1 | Bit clock, sampled by clk |
| fsync | input | 1 | Frame sync, sampled on bit ticks |
| p1_wcode | input | 3 | Phase 1 element width code |
| p1_cnt | input | 6 | Phase 1 element count minus one |
| p2_wcode | input | 3 | Phase 2 element width code |
| p2_cnt | input | 6 | Phase 2 element count minus one |
| p2_on | input | 1 | Enable phase 2 |
| p2_resync | input | 1 | Phase 2 waits for a new sync |
| lead_dly | input | 2 | Bit ticks from sync edge to first bit |
| sync_low | input | 1 | Sync active level is low |
| lsb_first | input | 1 | Send least significant bit first |
| rise_drive | input | 1 | Drive on rising bclk edges |
| sync_keep | input | 1 | Ignore mid-frame syncs |
| sdata | output | 1 | Serial data |
| busy | output | 1 | Frame in progress |
| underrun | output | 1 | One-cycle pulse: element started with empty queue |
| sync_err | output | 1 | One-cycle pulse: frame dropped by a mid-frame sync |

## Verification
Two functions can act on the same bit tick. In one case, an element boundary and an empty queue meet, so the fetch of the next word and the underrun decision happen together. In the other case, a data bit shifts out on the tick that a stray sync arrives, so the abort must win over the shift. The bench arranges both with directed frames that push fewer words than the frame needs and that inject a second sync several bits into an element. Random frames with random formats, widths and partly filled queues repeat the first case. Every tick is judged against a bit-by-bit expected stream that the bench builds from the requirements: data bit, busy, underrun and sync error all at once.

// File: rtl/sfx_pkg.sv
`timescale 1ns/1ps
package sfx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_SHIFT = 2'd2,
    ST_WAIT2 = 2'd3
  } sfx_state_e;

  // Element width in bits for a 3-bit width code.
  function automatic logic [5:0] elem_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd10;
      3'd2:    return 6'd12;
      3'd3:    return 6'd14;
      3'd4:    return 6'd16;
      3'd5:    return 6'd20;
      3'd6:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/sfx_fifo.sv
`timescale 1ns/1ps
module sfx_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R10
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R12

endmodule

// File: rtl/sfx_bitclk.sv
`timescale 1ns/1ps
module sfx_bitclk (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  input  logic rise_drive,
  input  logic sync_low,
  output logic tick,
  output logic fs_edge
);
  logic bclk_q;
  logic fs_prev;
  logic fs_act;

  assign fs_act  = fsync ^ sync_low;
  assign tick    = rise_drive ? (bclk & ~bclk_q) : (~bclk & bclk_q);
  assign fs_edge = tick & fs_act & ~fs_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (tick) fs_prev <= fs_act;
    end
  end

  AST_EDGE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    fs_edge |-> (bclk != bclk_q)); // R9

endmodule

// File: rtl/sfx_seq.sv
`timescale 1ns/1ps
module sfx_seq
  import sfx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fs_edge,
  input  logic [2:0]        p1_wcode,
  input  logic [5:0]        p1_cnt,
  input  logic [2:0]        p2_wcode,
  input  logic [5:0]        p2_cnt,
  input  logic              p2_on,
  input  logic              p2_resync,
  input  logic [1:0]        lead_dly,
  input  logic              lsb_first,
  input  logic              sync_keep,
  input  logic [WORD_W-1:0] head,
  input  logic              empty,
  output logic              pop,
  output logic              sdata,
  output logic              busy,
  output logic              underrun,
  output logic              sync_err
);
  sfx_state_e        state, st_n;
  logic              ph, ph_n;
  logic [5:0]        idx, idx_n;
  logic [5:0]        left, left_n;
  logic [1:0]        dly, dly_n;
  logic [WORD_W-1:0] sh, sh_n;
  logic              sd_n, busy_n, ur_n, err_n;
  logic              do_start, do_delay;
  logic [5:0]        eb;
  logic [WORD_W-1:0] word_v, mask_v;
  logic [5:0]        cur_cnt;

  assign cur_cnt = ph ? p2_cnt : p1_cnt;

  always_comb begin
    st_n = state; ph_n = ph; idx_n = idx; left_n = left; dly_n = dly;
    sh_n = sh; sd_n = sdata; busy_n = busy;
    pop = 1'b0; ur_n = 1'b0; err_n = 1'b0;
    do_start = 1'b0; do_delay = 1'b0;
    eb = 6'd8; word_v = '0; mask_v = '0;
    if (tick) begin
      unique case (state)
        ST_IDLE: if (fs_edge) begin
          busy_n = 1'b1; ph_n = 1'b0; idx_n = '0; do_delay = 1'b1;
        end
        ST_WAIT2: if (fs_edge) do_delay = 1'b1;
        ST_DELAY, ST_SHIFT: begin
          if (fs_edge && !sync_keep) begin
            st_n = ST_IDLE; busy_n = 1'b0; sd_n = 1'b0; err_n = 1'b1;
          end else if (state == ST_DELAY) begin
            if (dly == 2'd0) do_start = 1'b1;
            else dly_n = dly - 2'd1;
          end else if (left != 6'd1) begin
            sh_n   = lsb_first ? (sh >> 1) : (sh << 1);
            sd_n   = lsb_first ? sh_n[0] : sh_n[WORD_W-1];
            left_n = left - 6'd1;
          end else if (idx != cur_cnt) begin
            idx_n = idx + 6'd1; do_start = 1'b1;
          end else if (!ph && p2_on) begin
            ph_n = 1'b1; idx_n = '0;
            if (p2_resync) begin st_n = ST_WAIT2; sd_n = 1'b0; end
            else do_start = 1'b1;
          end else begin
            st_n = ST_IDLE; busy_n = 1'b0; sd_n = 1'b0;
          end
        end
      endcase
      if (do_delay) begin
        if (lead_dly == 2'd0) do_start = 1'b1;
        else begin st_n = ST_DELAY; dly_n = lead_dly - 2'd1; sd_n = 1'b0; end
      end
      if (do_start) begin
        eb     = elem_bits(ph_n ? p2_wcode : p1_wcode);
        mask_v = ~({WORD_W{1'b1}} << eb);
        word_v = empty ? '0 : (head & mask_v);
        pop    = !empty;
        ur_n   = empty;
        sh_n   = lsb_first ? word_v : (word_v << (WORD_W - int'(eb)));
        sd_n   = lsb_first ? sh_n[0] : sh_n[WORD_W-1];
        left_n = eb;
        st_n   = ST_SHIFT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; ph <= 1'b0; idx <= '0; left <= '0; dly <= '0;
      sh <= '0; sdata <= 1'b0; busy <= 1'b0; underrun <= 1'b0; sync_err <= 1'b0;
    end else begin
      state <= st_n; ph <= ph_n; idx <= idx_n; left <= left_n; dly <= dly_n;
      sh <= sh_n; sdata <= sd_n; busy <= busy_n; underrun <= ur_n; sync_err <= err_n;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdata); // R11
  AST_BUSY_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fs_edge)); // R11
  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!sdata && busy)); // R10
  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (!busy && !sync_keep)); // R8
  AST_SDATA_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(tick)); // R9

endmodule

// File: rtl/sfx_tx.sv
`timescale 1ns/1ps
module sfx_tx #(
  parameter int WORD_W = 32,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              bclk,
  input  logic              fsync,
  input  logic [2:0]        p1_wcode,
  input  logic [5:0]        p1_cnt,
  input  logic [2:0]        p2_wcode,
  input  logic [5:0]        p2_cnt,
  input  logic              p2_on,
  input  logic              p2_resync,
  input  logic [1:0]        lead_dly,
  input  logic              sync_low,
  input  logic              lsb_first,
  input  logic              rise_drive,
  input  logic              sync_keep,
  output logic              sdata,
  output logic              busy,
  output logic              underrun,
  output logic              sync_err
);
  logic              q_full, q_empty, q_pop, q_push;
  logic [WORD_W-1:0] q_head;
  logic              tick, fs_edge;

  assign in_ready = !q_full;
  assign q_push   = in_valid && !q_full;

  sfx_fifo #(.WORD_W(WORD_W), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(in_data),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  sfx_bitclk u_clk (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .rise_drive(rise_drive), .sync_low(sync_low),
    .tick(tick), .fs_edge(fs_edge)
  );

  sfx_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fs_edge(fs_edge),
    .p1_wcode(p1_wcode), .p1_cnt(p1_cnt), .p2_wcode(p2_wcode), .p2_cnt(p2_cnt),
    .p2_on(p2_on), .p2_resync(p2_resync), .lead_dly(lead_dly),
    .lsb_first(lsb_first), .sync_keep(sync_keep),
    .head(q_head), .empty(q_empty), .pop(q_pop),
    .sdata(sdata), .busy(busy), .underrun(underrun), .sync_err(sync_err)
  );

endmodule

// File: tb/sim_sfx_tx.sv
`timescale 1ns/1ps
module sim_sfx_tx;
  localparam int W = 32;
  localparam int N = 256;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0; logic in_ready; logic [W-1:0] in_data = '0;
  logic bclk = 0, fsync = 0;
  logic [2:0] p1_wcode = 0, p2_wcode = 0;
  logic [5:0] p1_cnt = 0, p2_cnt = 0;
  logic p2_on = 0, p2_resync = 0, sync_low = 0, lsb_first = 0, rise_drive = 1, sync_keep = 0;
  logic [1:0] lead_dly = 0;
  logic sdata, busy, underrun, sync_err;

  int checks = 0, fails = 0, cyc = 0;
  logic [W-1:0] wq [8];
  int wn = 0, wrd = 0;
  bit e_sd [N]; bit e_bz [N]; bit e_ur [N]; bit e_er [N]; bit fsp [N];
  int flen = 0;

  sfx_tx #(.WORD_W(W), .QDEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .bclk(bclk), .fsync(fsync), .p1_wcode(p1_wcode), .p1_cnt(p1_cnt),
    .p2_wcode(p2_wcode), .p2_cnt(p2_cnt), .p2_on(p2_on), .p2_resync(p2_resync),
    .lead_dly(lead_dly), .sync_low(sync_low), .lsb_first(lsb_first),
    .rise_drive(rise_drive), .sync_keep(sync_keep),
    .sdata(sdata), .busy(busy), .underrun(underrun), .sync_err(sync_err));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int wbits(input logic [2:0] c);
    case (c) 0: return 8; 1: return 10; 2: return 12; 3: return 14;
      4: return 16; 5: return 20; 6: return 24; default: return 32; endcase
  endfunction

  task automatic set_base();
    @(negedge clk);
    p1_wcode = 4; p1_cnt = 0; p2_wcode = 0; p2_cnt = 0; p2_on = 0; p2_resync = 0;
    lead_dly = 0; sync_low = 0; lsb_first = 0; rise_drive = 1; sync_keep = 0;
    fsync = 0; bclk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic apply_lines();
    @(negedge clk);
    fsync = sync_low; bclk = ~rise_drive;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] w);
    in_valid = 1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    wq[wn] = w; wn = wn + 1;
  endtask

  // Builds the expected stream; xs > 0 places a second sync at tick xs.
  task automatic gen(input int xs);
    int k; int t0; int last;
    for (int j = 0; j < N; j++) begin e_sd[j] = 0; e_bz[j] = 0; e_ur[j] = 0; e_er[j] = 0; fsp[j] = 0; end
    k = 2; t0 = k; fsp[k] = 1;
    for (int p = 0; p < (p2_on ? 2 : 1); p++) begin
      if (p == 1 && p2_resync) begin k = k + 2; fsp[k] = 1; end
      if (p == 0 || p2_resync) k = k + int'(lead_dly);
      for (int e = 0; e <= int'(p ? p2_cnt : p1_cnt); e++) begin
        int eb; logic [W-1:0] w;
        eb = wbits(p ? p2_wcode : p1_wcode);
        if (wrd < wn) begin
          w = wq[wrd]; wrd = wrd + 1;
          if (eb < 32) w = w & ((32'd1 << eb) - 1);
        end else begin w = '0; e_ur[k] = 1; end
        for (int b = 0; b < eb; b++) begin
          e_sd[k] = lsb_first ? w[b] : w[eb-1-b];
          k = k + 1;
        end
      end
    end
    last = k - 1;
    for (int j = t0; j <= last; j++) e_bz[j] = 1;
    flen = k + 3;
    if (xs > 0) begin
      fsp[xs] = 1;
      if (!sync_keep) begin
        for (int j = xs; j < N; j++) begin e_sd[j] = 0; e_bz[j] = 0; e_ur[j] = 0; end
        e_er[xs] = 1;
      end
    end
  endtask

  task automatic run(input string tag, input int xs);
    gen(xs);
    for (int j = 0; j < flen; j++) begin
      @(negedge clk);
      fsync = fsp[j] ^ sync_low; bclk = rise_drive;
      @(negedge clk);
      chk(tag, $sformatf("sdata tick %0d", j), int'(sdata), int'(e_sd[j]));
      chk("R11", $sformatf("busy tick %0d", j), int'(busy), int'(e_bz[j]));
      chk("R10", $sformatf("underrun tick %0d", j), int'(underrun), int'(e_ur[j]));
      chk("R8", $sformatf("sync_err tick %0d", j), int'(sync_err), int'(e_er[j]));
      bclk = ~rise_drive;
      repeat (2) @(negedge clk);
    end
    wn = 0; wrd = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "reset busy", int'(busy), 0);
    chk("R11", "reset sdata", int'(sdata), 0);
    chk("R12", "reset in_ready", int'(in_ready), 1);

    // R1: every width code, word with high bits set
    for (int c = 0; c < 8; c++) begin
      set_base(); p1_wcode = 3'(c); apply_lines();
      push(32'hF5C3_96E1 ^ (32'h0101_0101 * c)); run("R1", 0);
    end
    // R2: four elements in one phase
    set_base(); p1_wcode = 0; p1_cnt = 3; apply_lines();
    push(32'h11); push(32'hA2); push(32'h3C); push(32'hF4); run("R2", 0);
    // R3: dual phase, immediate start, different widths
    set_base(); p1_wcode = 4; p2_on = 1; p2_wcode = 0; p2_cnt = 1; apply_lines();
    push(32'h1234_BEEF); push(32'h5A); push(32'hC3); run("R3", 0);
    // R4: phase 2 waits for a new sync, with delay
    set_base(); p1_wcode = 1; p2_on = 1; p2_resync = 1; p2_wcode = 2; lead_dly = 2; apply_lines();
    push(32'h2AB); push(32'h9C7); run("R4", 0);
    // R5: all delays
    for (int d = 0; d < 4; d++) begin
      set_base(); lead_dly = 2'(d); p1_wcode = 0; apply_lines();
      push(32'h96); run("R5", 0);
    end
    // R6: active-low sync
    set_base(); sync_low = 1; lead_dly = 1; apply_lines();
    push(32'hB00C); run("R6", 0);
    // R7: lsb first
    set_base(); lsb_first = 1; p1_wcode = 5; apply_lines();
    push(32'h8_1E35); run("R7", 0);
    // R9: falling-edge drive
    set_base(); rise_drive = 0; p1_wcode = 3; apply_lines();
    push(32'h2D71); run("R9", 0);
    // R10: underrun on second element
    set_base(); p1_cnt = 1; p1_wcode = 0; apply_lines();
    push(32'hFF); run("R10", 0);
    // R8: mid-frame sync aborts, then is ignored
    set_base(); p1_wcode = 4; apply_lines();
    push(32'hFFFF); run("R8", 8);
    set_base(); p1_wcode = 4; sync_keep = 1; apply_lines();
    push(32'hA5F0); run("R8", 8);
    // R12: full queue drops ready, order kept
    set_base(); p1_wcode = 0; p1_cnt = 3; apply_lines();
    push(32'h01); push(32'h80); push(32'h7E); push(32'hC4);
    chk("R12", "in_ready when full", int'(in_ready), 0);
    run("R12", 0);
    chk("R12", "in_ready after drain", int'(in_ready), 1);

    // constrained random frames
    void'($urandom(32'h5EED_0042));
    for (int r = 0; r < 40; r++) begin
      int tot; int n;
      set_base();
      p1_wcode = 3'($urandom % 8); p1_cnt = 6'($urandom % 2);
      p2_on = 1'($urandom % 2); p2_wcode = 3'($urandom % 8); p2_cnt = 6'($urandom % 2);
      p2_resync = 1'($urandom % 2); lead_dly = 2'($urandom % 4);
      sync_low = 1'($urandom % 2); lsb_first = 1'($urandom % 2);
      rise_drive = 1'($urandom % 2); sync_keep = 1'($urandom % 2);
      apply_lines();
      tot = int'(p1_cnt) + 1 + (p2_on ? int'(p2_cnt) + 1 : 0);
      n = (r % 5 == 0) ? int'($urandom % tot) : tot;
      for (int i = 0; i < n; i++) push($urandom);
      run("RAND", 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule